// File: doc/BRIEF.md
# Secondary Configuration Address Translator

This block sits between a CPU-side window of 512 KB and a downstream configuration bus. Each CPU access into the window is turned into a type-0 configuration cycle address. The low 16 bits of the window offset are joined with a 16-bit upper field held in a mapping register. A one-hot device-select field in the joined address is reduced to a device number by taking its lowest set bit. The block then issues one bus cycle and returns read data to the requester. It also pulses a request to clear the two received-abort bits of the local status register.

Some requests produce no bus cycle. When the mapping register's disable bit is set, reads return all ones for the access size and writes are discarded. A request whose device-select field is zero sets a sticky error flag. While that flag is set, every later request is completed locally in the same way as a disabled one. Only reset clears the flag.

Control is a three-state machine. `ST_IDLE` waits for a request. From there, `go_bus` moves to `ST_BUS` when the request translates cleanly, and `go_local` moves to `ST_RESP` when the request is disabled, in error, or has a zero select field. `ST_BUS` holds the cycle until the downstream side reports completion, and `bus_done` then moves to `ST_RESP`. `ST_RESP` presents the response for one clock, and `resp_end` returns to `ST_IDLE`.

Top module: `cfgx_xlate`

## Requirements
- R1: When `map_cfg` bit 16 is set, no bus cycle is issued. A read responds with all ones for its size: `req_size` 0 = byte gives 0x000000FF, 1 = halfword gives 0x0000FFFF, and 2 or 3 = word gives 0xFFFFFFFF. A write is discarded. `cfg_err` is left unchanged.
- R2: The joined 32-bit address has `req_ofs[15:0]` in bits 15:0 and `map_cfg[15:0]` in bits 31:16. Offset bits 18:16 have no effect.
- R3: The device-select field is bits 31:11 of the joined address. The device number is the index of its lowest set bit and appears in `cyc_addr[15:11]`. Higher set bits are ignored.
- R4: `cyc_addr[10:8]` carries the function number from joined bits 10:8. `cyc_addr[7:2]` carries the register number from joined bits 7:2. `cyc_addr[1:0]` is zero, and offset bits 1:0 appear on `cyc_byte`.
- R5: `cyc_addr[23:16]` equals `bus_num`, `cyc_addr[31]` is 1, and `cyc_addr[30:24]` is 0.
- R6: An enabled request whose device-select field is zero issues no cycle. It sets `cfg_err`, which is visible by the response cycle, and a read responds with all ones for its size.
- R7: Once `cfg_err` is set, every request completes without a bus cycle, and the flag stays set until reset.
- R8: In the response cycle of every request that ran a bus cycle, `abort_clr` is high together with `rsp_valid`. It is low for requests completed locally.
- R9: The cycle carries the access size on `cyc_size`, the direction on `cyc_write` and the data on `cyc_wdata`. A read returns `cyc_rdata`, sampled with `cyc_done`, on `rsp_rdata` in the next clock.
- R10: A request is taken only while `req_ready` is high. `cyc_valid` and every `cyc_*` field stay stable until `cyc_done`, and `rsp_valid` lasts exactly one clock.
- R11: After reset, `cfg_err`, `cyc_valid`, `rsp_valid` and `abort_clr` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Request accepted this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_ofs | input | 19 | Byte offset inside the window |
| req_wdata | input | 32 | Write data |
| map_cfg | input | 32 | Mapping register: bits 15:0 upper address, bit 16 disable |
| bus_num | input | 8 | Downstream bus number |
| cyc_valid | output | 1 | Configuration cycle active |
| cyc_done | input | 1 | Downstream cycle complete |
| cyc_write | output | 1 | Cycle direction |
| cyc_size | output | 2 | Cycle access size |
| cyc_byte | output | 2 | Byte offset within the dword |
| cyc_addr | output | 32 | Configuration address with enable bit 31 |
| cyc_wdata | output | 32 | Cycle write data |
| cyc_rdata | input | 32 | Cycle read data |
| rsp_valid | output | 1 | Response to the CPU |
| rsp_rdata | output | 32 | Read response data |
| abort_clr | output | 1 | Clear received master/target abort status |
| cfg_err | output | 1 | Sticky zero-select error |

## Verification
Two events can land in the same clock. The response to a request and the abort-status clear request coincide whenever a bus cycle ran, and a newly raised error flag coincides with the local response of the request that raised it. The bench drives mixed sequences in which bus-backed and locally completed requests alternate back to back, including a zero-select request that follows a good one. For each response, the scoreboard expects the data, the `abort_clr` value and the `cfg_err` value together in that single clock. A missing, extra or misplaced pulse is therefore reported against the request that caused it.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUS  = 2'd1,
        ST_RESP = 2'd2
    } xl_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

    // all-ones pattern for a local (no-cycle) read of the given size
    function automatic logic [31:0] size_ones(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: size_ones = 32'h0000_00FF;
            SZ_HALF: size_ones = 32'h0000_FFFF;
            default: size_ones = 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/cfgx_lowbit.sv
module cfgx_lowbit #(
    parameter int W  = 21,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          none
);
    always_comb begin
        idx  = '0;
        none = 1'b1;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx  = IW'(i);
                none = 1'b0;
            end
        end
    end

    // R3
    always_comb begin
        if (!none) begin
            lowest_bit_chk: assert (vec[idx] && ((vec & ((W'(1) << idx) - W'(1))) == '0));
        end
    end

endmodule

// File: rtl/cfgx_addr_map.sv
module cfgx_addr_map #(
    parameter int OFS_W = 19,
    parameter int BUS_W = 8
) (
    input  logic [OFS_W-1:0] ofs,
    input  logic [15:0]      upper,
    input  logic [BUS_W-1:0] bus,
    output logic [31:0]      addr,
    output logic             zero_sel
);
    localparam int SEL_LO = 11;
    localparam int SEL_W  = 32 - SEL_LO;
    localparam int DEV_W  = $clog2(SEL_W);

    logic [31:0]      joined;
    logic [SEL_W-1:0] sel;
    logic [DEV_W-1:0] dev;
    logic [2:0]       fun;
    logic [5:0]       regn;

    assign joined = {upper, ofs[15:0]};
    assign sel    = joined[31:SEL_LO];
    assign fun    = joined[10:8];
    assign regn   = joined[7:2];

    cfgx_lowbit #(.W(SEL_W)) u_lowbit (
        .vec  (sel),
        .idx  (dev),
        .none (zero_sel)
    );

    assign addr = 32'h8000_0000
                | (32'(bus) << 16)
                | (32'(dev) << SEL_LO)
                | (32'(fun) << 8)
                | (32'(regn) << 2);

endmodule

// File: rtl/cfgx_xlate.sv
module cfgx_xlate
    import cfgx_pkg::*;
#(
    parameter int OFS_W   = 19,
    parameter int BUS_W   = 8,
    parameter int DIS_BIT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [1:0]       req_size,
    input  logic [OFS_W-1:0] req_ofs,
    input  logic [31:0]      req_wdata,
    input  logic [31:0]      map_cfg,
    input  logic [BUS_W-1:0] bus_num,
    output logic             cyc_valid,
    input  logic             cyc_done,
    output logic             cyc_write,
    output logic [1:0]       cyc_size,
    output logic [1:0]       cyc_byte,
    output logic [31:0]      cyc_addr,
    output logic [31:0]      cyc_wdata,
    input  logic [31:0]      cyc_rdata,
    output logic             rsp_valid,
    output logic [31:0]      rsp_rdata,
    output logic             abort_clr,
    output logic             cfg_err
);
    xl_state_e   state_q, state_d;
    logic [31:0] map_addr;
    logic        zero_sel;
    logic        disabled;
    logic        accept;
    logic        local_done;
    logic        issued_q;
    logic        err_q;
    logic [31:0] addr_q, wdata_q, rdata_q;
    logic [1:0]  size_q, byte_q;
    logic        write_q;

    cfgx_addr_map #(.OFS_W(OFS_W), .BUS_W(BUS_W)) u_map (
        .ofs      (req_ofs),
        .upper    (map_cfg[15:0]),
        .bus      (bus_num),
        .addr     (map_addr),
        .zero_sel (zero_sel)
    );

    assign disabled   = map_cfg[DIS_BIT];
    assign accept     = (state_q == ST_IDLE) && req_valid;
    assign local_done = disabled || err_q || zero_sel;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = local_done ? ST_RESP : ST_BUS;
            ST_BUS:  if (cyc_done)  state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and sticky error
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q    <= 1'b0;
            issued_q <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            size_q   <= '0;
            byte_q   <= '0;
            write_q  <= 1'b0;
        end else begin
            if (accept) begin
                addr_q   <= map_addr;
                wdata_q  <= req_wdata;
                size_q   <= req_size;
                byte_q   <= req_ofs[1:0];
                write_q  <= req_write;
                issued_q <= 1'b0;
                if (local_done) rdata_q <= size_ones(req_size);
                if (!disabled && zero_sel) err_q <= 1'b1;
            end
            if ((state_q == ST_BUS) && cyc_done) begin
                rdata_q  <= cyc_rdata;
                issued_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        cyc_valid = (state_q == ST_BUS);
        rsp_valid = (state_q == ST_RESP);
        abort_clr = (state_q == ST_RESP) && issued_q;
        cyc_write = write_q;
        cyc_size  = size_q;
        cyc_byte  = byte_q;
        cyc_addr  = addr_q;
        cyc_wdata = wdata_q;
        rsp_rdata = rdata_q;
        cfg_err   = err_q;
    end

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    // R7
    no_cyc_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid |-> !cfg_err);

    // R10
    cyc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && !cyc_done) |=> (cyc_valid && $stable(cyc_addr) && $stable(cyc_wdata)));

    // R10
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R8
    clr_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_clr |-> rsp_valid);

    // R5
    cyc_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid |-> (cyc_addr[31] && cyc_addr[30:24] == 7'd0));

endmodule

// File: tb/tb_cfgx_xlate.sv
module tb_cfgx_xlate;

    typedef struct {
        logic [31:0] addr;
        logic        wr;
        logic [1:0]  sz;
        logic [1:0]  byt;
        logic [31:0] wd;
        string       req;
    } cyc_t;

    typedef struct {
        logic        chk;
        logic [31:0] data;
        logic        clr;
        logic        err;
        string       req;
    } rsp_t;

    localparam logic [31:0] RD_KEY = 32'h5A5A_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [18:0] req_ofs = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] map_cfg = '0;
    logic [7:0]  bus_num = 8'h00;
    logic        cyc_valid, cyc_write;
    logic        cyc_done = 1'b0;
    logic [1:0]  cyc_size, cyc_byte;
    logic [31:0] cyc_addr, cyc_wdata;
    logic [31:0] cyc_rdata = '0;
    logic        rsp_valid, abort_clr, cfg_err;
    logic [31:0] rsp_rdata;

    int   n_chk = 0;
    int   n_fail = 0;
    logic err_model = 1'b0;
    logic finished = 1'b0;
    cyc_t cyc_q[$];
    rsp_t rsp_q[$];

    always #5 clk = ~clk;

    cfgx_xlate dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_size(req_size), .req_ofs(req_ofs),
        .req_wdata(req_wdata), .map_cfg(map_cfg), .bus_num(bus_num),
        .cyc_valid(cyc_valid), .cyc_done(cyc_done), .cyc_write(cyc_write),
        .cyc_size(cyc_size), .cyc_byte(cyc_byte), .cyc_addr(cyc_addr),
        .cyc_wdata(cyc_wdata), .cyc_rdata(cyc_rdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .abort_clr(abort_clr), .cfg_err(cfg_err)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ones_of(input logic [1:0] sz);
        if (sz == 2'd0)      return 32'h0000_00FF;
        else if (sz == 2'd1) return 32'h0000_FFFF;
        else                 return 32'hFFFF_FFFF;
    endfunction

    // driver: builds expected items from the requirements, then presents the request
    task automatic xfer(input logic wr, input logic [1:0] sz, input logic [18:0] ofs,
                        input logic [31:0] wd, input string req);
        logic [31:0] joined, exp_addr;
        logic [20:0] sel;
        int          dev;
        cyc_t        c;
        rsp_t        r;
        joined = {map_cfg[15:0], ofs[15:0]};
        sel    = joined[31:11];
        dev    = -1;
        for (int i = 0; i < 21; i++) if (sel[i] && dev < 0) dev = i;
        r.req = req;
        if (map_cfg[16]) begin                                  // R1
            r.chk = !wr; r.data = ones_of(sz); r.clr = 1'b0; r.err = err_model;
        end else if (err_model || dev < 0) begin                // R6, R7
            err_model = 1'b1;
            r.chk = !wr; r.data = ones_of(sz); r.clr = 1'b0; r.err = 1'b1;
        end else begin                                          // R2..R5, R8, R9
            exp_addr = 32'h8000_0000 | (32'(bus_num) << 16) | (32'(dev) << 11)
                     | (32'(joined[10:8]) << 8) | (32'(joined[7:2]) << 2);
            c.addr = exp_addr; c.wr = wr; c.sz = sz; c.byt = ofs[1:0]; c.wd = wd; c.req = req;
            cyc_q.push_back(c);
            r.chk = !wr; r.data = exp_addr ^ RD_KEY; r.clr = 1'b1; r.err = 1'b0;
        end
        rsp_q.push_back(r);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_ofs = ofs; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        int t = 0;
        while ((cyc_q.size() != 0 || rsp_q.size() != 0) && t < 100) begin
            @(negedge clk); t++;
        end
        repeat (2) @(negedge clk);
    endtask

    // downstream responder: compares each issued cycle against the scoreboard
    int wait_cnt = 0;
    int lat_sel = 0;
    initial forever begin
        @(negedge clk);
        if (cyc_done) begin
            cyc_done = 1'b0;
        end else if (cyc_valid) begin
            wait_cnt++;
            if (wait_cnt >= 1 + (lat_sel % 3)) begin
                cyc_t c;
                wait_cnt = 0; lat_sel++;
                if (cyc_q.size() == 0) begin
                    check(1'b0, "R1/R6/R7 unexpected cycle", cyc_addr, 32'h0);
                end else begin
                    c = cyc_q.pop_front();
                    check(cyc_addr == c.addr, c.req, cyc_addr, c.addr);
                    check({cyc_write, cyc_size, cyc_byte} == {c.wr, c.sz, c.byt}, {c.req, " R9/R4 ctl"},
                          32'({cyc_write, cyc_size, cyc_byte}), 32'({c.wr, c.sz, c.byt}));
                    if (c.wr) check(cyc_wdata == c.wd, {c.req, " R9 wdata"}, cyc_wdata, c.wd);
                end
                cyc_rdata = cyc_addr ^ RD_KEY;
                cyc_done  = 1'b1;
            end
        end
    end

    // monitor: pops expected responses as the design produces them
    initial forever begin
        @(negedge clk);
        if (rst_n && rsp_valid) begin
            rsp_t r;
            if (rsp_q.size() == 0) begin
                check(1'b0, "R10 unexpected response", rsp_rdata, 32'h0);
            end else begin
                r = rsp_q.pop_front();
                if (r.chk) check(rsp_rdata == r.data, {r.req, " data"}, rsp_rdata, r.data);
                check(abort_clr == r.clr, {r.req, " R8 abort_clr"}, 32'(abort_clr), 32'(r.clr));
                check(cfg_err == r.err, {r.req, " R6/R7 cfg_err"}, 32'(cfg_err), 32'(r.err));
            end
        end
    end

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog", 32'h0, 32'h1);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check({cfg_err, cyc_valid, rsp_valid, abort_clr, req_ready} == 5'b00001, "R11 reset",
              32'({cfg_err, cyc_valid, rsp_valid, abort_clr, req_ready}), 32'h1);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R5 R9: translated reads and writes of all sizes
        bus_num = 8'h3C; map_cfg = 32'h0000_0001;
        xfer(1'b0, 2'd2, 19'h0_1234, 32'h0, "R2 R3 word read");
        xfer(1'b1, 2'd0, 19'h7_0A07, 32'hDEAD_BEEF, "R2 R4 byte write high ofs bits");
        map_cfg = 32'h0000_8000; bus_num = 8'hA5;
        xfer(1'b0, 2'd1, 19'h0_0002, 32'h0, "R3 top select bit halfword");
        map_cfg = 32'h0000_0000;
        xfer(1'b0, 2'd0, 19'h0_0FFD, 32'h0, "R3 select bit zero");
        map_cfg = 32'h0000_F0F0; bus_num = 8'h00;
        xfer(1'b1, 2'd3, 19'h0_F8FC, 32'h1234_5678, "R3 R5 multi-bit select");
        xfer(1'b0, 2'd2, 19'h0_7E44, 32'h0, "R4 R9 function register");
        drain();

        // R1: disabled window, all sizes, write dropped, zero select not an error
        map_cfg = 32'h0001_0004;
        xfer(1'b0, 2'd0, 19'h0_0100, 32'h0, "R1 disabled byte");
        xfer(1'b0, 2'd1, 19'h0_0100, 32'h0, "R1 disabled half");
        xfer(1'b0, 2'd2, 19'h0_0100, 32'h0, "R1 disabled word");
        xfer(1'b1, 2'd2, 19'h0_0100, 32'hFFFF_0000, "R1 disabled write");
        map_cfg = 32'h0001_0000;
        xfer(1'b0, 2'd2, 19'h0_0010, 32'h0, "R1 disabled zero select");
        map_cfg = 32'h0000_0002;
        xfer(1'b0, 2'd2, 19'h0_0020, 32'h0, "R8 cycle after local");
        drain();

        // R6 R7: zero select sets sticky error, later requests complete locally
        map_cfg = 32'h0000_0000;
        xfer(1'b0, 2'd1, 19'h0_0700, 32'h0, "R6 zero select");
        map_cfg = 32'h0000_0040;
        xfer(1'b0, 2'd2, 19'h0_0000, 32'h0, "R7 blocked read");
        xfer(1'b1, 2'd0, 19'h0_0000, 32'h55, "R7 blocked write");
        drain();
        check(cfg_err == 1'b1, "R7 flag held", 32'(cfg_err), 32'h1);

        // R7 R11: only reset clears the error
        @(negedge clk); rst_n = 1'b0; err_model = 1'b0;
        @(negedge clk);
        check(cfg_err == 1'b0, "R7 R11 cleared by reset", 32'(cfg_err), 32'h0);
        rst_n = 1'b1;
        xfer(1'b0, 2'd2, 19'h0_0804, 32'h0, "R7 recovered read");
        drain();

        check(cyc_q.size() == 0, "R9 cycles consumed", 32'(cyc_q.size()), 32'h0);
        check(rsp_q.size() == 0, "R10 responses consumed", 32'(rsp_q.size()), 32'h0);
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule